// File: doc/BRIEF.md
# Line-Cycle Gated Energy Accumulator

This block integrates signed active-power samples over a window measured in zero crossings of the line voltage rather than in clock cycles. Every accepted sample is first corrected by a signed offset and a signed fractional gain. It is then added into a wide accumulator. Zero-crossing strobes from up to three phases, each gated by its own enable bit, count the remaining crossings down. When the programmed number has been seen, the window total is divided, clipped to 16 bits and latched into the result register, and a one-cycle completion pulse is raised. The next window then starts from an empty accumulator.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is held high and a sample is taken on every cycle in which `in_valid` is high. All configuration inputs are plain levels, and the block samples them every cycle. The crossing count is captured only when a window starts, so a new count takes effect from the next window.

Top module: `lc_energy_acc`

## Requirements
- R1: Bit 0 of `mode_cfg` enables line-cycle accumulation. While it is 0, `done_pulse` stays low, `energy_out` holds its value and the accumulator is emptied. The first cycle with bit 0 high starts a fresh window.
- R2: Bits 3, 4 and 5 of `mode_cfg` enable counting of `zx_strobe[0]`, `zx_strobe[1]` and `zx_strobe[2]` (phases A, B, C). A strobe whose enable bit is 0 has no effect.
- R3: A window closes in the cycle in which the enabled strobes seen since the window began reach `cycle_count`. A count of 0 is treated as 1. Strobes that arrive in the same cycle each count, and any crossings beyond the number needed to close the window are discarded.
- R4: `energy_out` changes only at the clock edge that closes a window, and `done_pulse` is high for exactly the cycle after that edge.
- R5: Each accepted sample contributes floor((sample + offset) * (4096 + gain) / 4096), where sample, `power_offset` and `power_gain` are two's-complement values.
- R6: The accumulator is 40 bits wide. It is empty at the start of every window, and a sample accepted in the closing cycle belongs to the window that closes.
- R7: The result is the window total divided by `energy_div`, truncated toward zero, with a divider of 0 treated as 1. It is then saturated to the range -32768..32767.
- R8: Bit 6 of `mode_cfg` (reset-on-read) has no effect while bit 0 is set.
- R9: `in_ready` is always high, and a sample is accepted in every cycle with `in_valid` high.
- R10: After reset `energy_out` is 0 and `done_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Power sample valid |
| in_ready | output | 1 | Sample accepted (always 1) |
| in_power | input | PW (24) | Signed active-power sample |
| zx_strobe | input | 3 | Zero-crossing strobes, phases A..C in bits 0..2 |
| mode_cfg | input | 8 | Mode: bit0 enable, bits3-5 phase enables, bit6 reset-on-read |
| cycle_count | input | 16 | Crossings per window (0 means 1) |
| power_offset | input | 12 | Signed offset added to each sample |
| power_gain | input | 12 | Signed gain trim, factor (4096+gain)/4096 |
| energy_div | input | 8 | Result divider (0 means 1) |
| energy_out | output | 16 | Signed window energy |
| done_pulse | output | 1 | One-cycle window completion flag |

## Verification
The bench builds the block with its default widths: 24-bit samples, a 40-bit accumulator and a 16-bit crossing counter. It keeps crossing counts between 0 and 4 so that many short windows, same-cycle strobe bursts and the zero-count case come up often. It drives samples in the millions so that both saturation limits are reached. Divider values span 0 to 255, and offsets and gains take negative values, which exercises floor rounding in the scaling step and truncation toward zero in the division.

// File: rtl/lc_energy_pkg.sv
package lc_energy_pkg;
  localparam int NPH         = 3;   // phases with zero-crossing strobes
  localparam int MODE_EN_BIT = 0;   // line-cycle accumulation enable
  localparam int MODE_ZX_LSB = 3;   // first phase-enable bit
  localparam int MODE_RR_BIT = 6;   // reset-on-read, ignored in this mode
  localparam int GAIN_FRAC   = 12;  // fractional bits of the gain factor
  localparam int OUT_W       = 16;  // result width
endpackage

// File: rtl/lc_scale.sv
module lc_scale #(
  parameter  int PW = 24,
  parameter  int CW = 12,
  localparam int SW = PW + 3
) (
  input  logic signed [PW-1:0] sample_i,
  input  logic        [CW-1:0] offset_i,
  input  logic        [CW-1:0] gain_i,
  output logic signed [SW-1:0] scaled_o
);
  localparam int PRW = PW + CW + 3;

  logic signed [PW:0]     sum;
  logic signed [CW+1:0]   factor;
  logic signed [PRW-1:0]  prod;

  // offset is sign-extended to the sample width plus one guard bit
  assign sum    = $signed({sample_i[PW-1], sample_i}) +
                  $signed({{(PW+1-CW){offset_i[CW-1]}}, offset_i});
  // unity plus a signed trim: 2^CW + gain
  assign factor = $signed({2'b01, {CW{1'b0}}}) +
                  $signed({{2{gain_i[CW-1]}}, gain_i});
  assign prod     = PRW'(sum) * PRW'(factor);
  assign scaled_o = SW'(prod >>> CW);
endmodule

// File: rtl/lc_zx_window.sv
module lc_zx_window #(
  parameter int NP   = 3,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [NP-1:0]   zx_i,
  input  logic [NP-1:0]   mask_i,
  input  logic [CNTW-1:0] count_i,
  output logic [CNTW-1:0] rem_o,
  output logic            active_o,
  output logic            end_o
);
  localparam int HW = $clog2(NP + 1);

  logic [NP-1:0]   hit;
  logic [HW-1:0]   hits;
  logic [CNTW-1:0] load_val;
  logic [CNTW-1:0] rem_eff;
  logic [CNTW-1:0] rem_q;
  logic            active_q;

  for (genvar g = 0; g < NP; g++) begin : g_phase
    assign hit[g] = zx_i[g] & mask_i[g];
  end

  always_comb begin
    hits = '0;
    for (int i = 0; i < NP; i++) hits = hits + HW'(hit[i]);
  end

  assign load_val = (count_i == '0) ? CNTW'(1) : count_i;
  // the first cycle of a window sees the freshly loaded count
  assign rem_eff  = active_q ? rem_q : load_val;
  assign end_o    = en_i && (CNTW'(hits) >= rem_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rem_q    <= CNTW'(1);
    end else if (!en_i) begin
      active_q <= 1'b0;
      rem_q    <= load_val;
    end else begin
      active_q <= 1'b1;
      rem_q    <= end_o ? load_val : rem_eff - CNTW'(hits);
    end
  end

  assign rem_o    = rem_q;
  assign active_o = active_q;
endmodule

// File: rtl/lc_div_sat.sv
module lc_div_sat #(
  parameter int AW = 40,
  parameter int DW = 8,
  parameter int OW = 16
) (
  input  logic signed [AW-1:0] acc_i,
  input  logic        [DW-1:0] div_i,
  output logic signed [OW-1:0] q_o
);
  localparam logic signed [AW-1:0] QMAX = (AW'(1) <<< (OW-1)) - AW'(1);
  localparam logic signed [AW-1:0] QMIN = -QMAX - AW'(1);

  logic signed [AW-1:0] den;
  logic signed [AW-1:0] quot;

  assign den  = (div_i == '0) ? AW'(1) : AW'(div_i);
  assign quot = acc_i / den;

  always_comb begin
    if (quot > QMAX)      q_o = OW'(QMAX);
    else if (quot < QMIN) q_o = OW'(QMIN);
    else                  q_o = OW'(quot);
  end
endmodule

// File: rtl/lc_energy_acc.sv
module lc_energy_acc
  import lc_energy_pkg::*;
#(
  parameter int PW   = 24,
  parameter int AW   = 40,
  parameter int CNTW = 16,
  parameter int CW   = 12,
  parameter int DW   = 8,
  parameter int MW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [PW-1:0]       in_power,
  input  logic [NPH-1:0]      zx_strobe,
  input  logic [MW-1:0]       mode_cfg,
  input  logic [CNTW-1:0]     cycle_count,
  input  logic [CW-1:0]       power_offset,
  input  logic [CW-1:0]       power_gain,
  input  logic [DW-1:0]       energy_div,
  output logic [OUT_W-1:0]    energy_out,
  output logic                done_pulse
);
  localparam int SW = PW + 3;

  logic                  acc_en;
  logic [NPH-1:0]        zx_mask;
  logic                  take;
  logic signed [SW-1:0]  scaled;
  logic signed [AW-1:0]  acc_q;
  logic signed [AW-1:0]  acc_base;
  logic signed [AW-1:0]  acc_sum;
  logic signed [OUT_W-1:0] quot;
  logic [CNTW-1:0]       rem_q;
  logic                  active_q;
  logic                  win_end;
  logic                  unused_mode_bits;

  assign in_ready = 1'b1;
  assign take     = in_valid & in_ready;
  assign acc_en   = mode_cfg[MODE_EN_BIT];
  assign zx_mask  = mode_cfg[MODE_ZX_LSB +: NPH];
  // reset-on-read (bit 6) and spare bits have no role in this mode
  assign unused_mode_bits = ^{mode_cfg[MW-1:MODE_RR_BIT], mode_cfg[MODE_ZX_LSB-1:1]};

  lc_scale #(.PW(PW), .CW(CW)) u_scale (
    .sample_i (in_power),
    .offset_i (power_offset),
    .gain_i   (power_gain),
    .scaled_o (scaled)
  );

  lc_zx_window #(.NP(NPH), .CNTW(CNTW)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (acc_en),
    .zx_i     (zx_strobe),
    .mask_i   (zx_mask),
    .count_i  (cycle_count),
    .rem_o    (rem_q),
    .active_o (active_q),
    .end_o    (win_end)
  );

  assign acc_base = active_q ? acc_q : '0;
  assign acc_sum  = acc_base + (take ? AW'(scaled) : AW'(0));

  lc_div_sat #(.AW(AW), .DW(DW), .OW(OUT_W)) u_div (
    .acc_i (acc_sum),
    .div_i (energy_div),
    .q_o   (quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      energy_out <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= win_end;
      if (!acc_en) begin
        acc_q <= '0;
      end else if (win_end) begin
        acc_q      <= '0;
        energy_out <= quot;
      end else begin
        acc_q <= acc_sum;
      end
    end
  end
endmodule

// File: rtl/lc_energy_acc_chk.sv
module lc_energy_acc_chk #(
  parameter int AW   = 40,
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      mode_cfg,
  input logic            done_pulse,
  input logic [15:0]     energy_out,
  input logic            active_q,
  input logic [CNTW-1:0] rem_q,
  input logic [AW-1:0]   acc_q
);
  // R1: a disabled cycle cannot close a window
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_cfg[0] |=> !done_pulse);

  // R1: every completion follows an enabled cycle
  p_done_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(mode_cfg[0]));

  // R4: result only moves together with the completion flag
  p_energy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |-> $stable(energy_out));

  // R3: a running window always has crossings left to wait for
  p_rem_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (rem_q != '0));

  // R6: a new window begins with an empty accumulator
  p_fresh_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (acc_q == '0));
endmodule

bind lc_energy_acc lc_energy_acc_chk #(.AW(AW), .CNTW(CNTW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_cfg   (mode_cfg),
  .done_pulse (done_pulse),
  .energy_out (energy_out),
  .active_q   (active_q),
  .rem_q      (rem_q),
  .acc_q      (acc_q)
);

// File: tb/lc_energy_acc_test.sv
module lc_energy_acc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_power = '0;
  logic [2:0]  zx_strobe = '0;
  logic [7:0]  mode_cfg = '0;
  logic [15:0] cycle_count = '0;
  logic [11:0] power_offset = '0;
  logic [11:0] power_gain = '0;
  logic [7:0]  energy_div = 8'd1;
  logic [15:0] energy_out;
  logic        done_pulse;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference state
  bit     m_active = 1'b0;
  longint m_rem = 1;
  longint m_acc = 0;
  longint m_energy = 0;
  bit     m_done = 1'b0;

  always #5 clk = ~clk;

  lc_energy_acc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_power(in_power), .zx_strobe(zx_strobe), .mode_cfg(mode_cfg),
    .cycle_count(cycle_count), .power_offset(power_offset),
    .power_gain(power_gain), .energy_div(energy_div),
    .energy_out(energy_out), .done_pulse(done_pulse)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint scale_ref(input longint s);
    longint sum = s + longint'($signed(power_offset));
    longint f   = 4096 + longint'($signed(power_gain));
    return (sum * f) >>> 12;
  endfunction

  function automatic longint divsat_ref(input longint a);
    longint d = (energy_div == 0) ? 1 : longint'(energy_div);
    longint q = a / d;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  // one clock: drive, advance the model, check after the edge
  task automatic step(input bit v, input longint s, input bit [2:0] z);
    longint rem, acc, nload;
    int hits;
    in_valid  = v;
    in_power  = s[23:0];
    zx_strobe = z;
    nload = (cycle_count == 0) ? 1 : longint'(cycle_count);
    if (!mode_cfg[0]) begin
      m_active = 1'b0;
      m_acc    = 0;
      m_done   = 1'b0;
    end else begin
      rem = m_active ? m_rem : nload;
      acc = m_active ? m_acc : 0;
      if (v) acc = acc + scale_ref(s);
      acc = (acc <<< 24) >>> 24;
      hits = 0;
      for (int i = 0; i < 3; i++) if (z[i] && mode_cfg[3+i]) hits++;
      if (hits >= rem) begin
        m_energy = divsat_ref(acc);
        m_done   = 1'b1;
        m_acc    = 0;
        m_rem    = nload;
      end else begin
        m_done = 1'b0;
        m_acc  = acc;
        m_rem  = rem - hits;
      end
      m_active = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(done_pulse == m_done, "R4 done_pulse", longint'(done_pulse), longint'(m_done));
    chk(longint'($signed(energy_out)) == m_energy, "R4 energy_out",
        longint'($signed(energy_out)), m_energy);
    chk(in_ready == 1'b1, "R9 in_ready", longint'(in_ready), 1);
  endtask

  task automatic expect_done(input string tag, input longint e);
    chk(done_pulse == 1'b1, tag, longint'(done_pulse), 1);
    chk(longint'($signed(energy_out)) == e, tag, longint'($signed(energy_out)), e);
  endtask

  task automatic restart(input bit [7:0] m, input int n);
    mode_cfg = 8'h00;
    step(0, 0, 3'b000);
    mode_cfg    = m;
    cycle_count = 16'(n);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk(energy_out == 16'd0, "R10 energy after reset", longint'(energy_out), 0);
    chk(done_pulse == 1'b0, "R10 done after reset", longint'(done_pulse), 0);
    chk(in_ready == 1'b1, "R9 ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    step(0, 0, 3'b000);

    // R2: only phase A counts; B and C strobes ignored
    restart(8'h09, 2);
    step(1, 100, 3'b110);
    chk(done_pulse == 0, "R2 masked strobes", longint'(done_pulse), 0);
    step(1, 100, 3'b010);
    step(1, 50, 3'b001);
    chk(done_pulse == 0, "R2 one of two crossings", longint'(done_pulse), 0);
    step(1, 25, 3'b001);
    expect_done("R6 closing sample included", 275);

    // R3: simultaneous strobes each count
    restart(8'h39, 3);
    step(1, 10, 3'b111);
    expect_done("R3 three strobes one cycle", 10);

    // R3: excess crossings discarded
    restart(8'h39, 2);
    step(0, 0, 3'b111);
    expect_done("R3 excess burst", 0);
    step(1, 7, 3'b001);
    chk(done_pulse == 0, "R3 excess not carried", longint'(done_pulse), 0);
    step(1, 7, 3'b001);
    expect_done("R3 next window", 14);

    // R3: count of zero behaves as one
    restart(8'h39, 0);
    step(1, 5, 3'b001);
    expect_done("R3 zero count", 5);

    // R5: offset and gain with floor rounding
    restart(8'h39, 1);
    power_offset = 12'hFFD; power_gain = 12'h800;
    step(1, 101, 3'b001);
    expect_done("R5 half gain positive", 49);
    step(1, -101, 3'b001);
    expect_done("R5 half gain negative", -52);
    power_offset = 12'h000; power_gain = 12'd1024;
    step(1, -7, 3'b001);
    expect_done("R5 floor of -8.75", -9);

    // R7: divider, zero divider and saturation
    power_gain = 12'h000;
    energy_div = 8'd0;
    step(1, 1000, 3'b001);
    expect_done("R7 divider zero", 1000);
    energy_div = 8'd7;
    step(1, -1000, 3'b001);
    expect_done("R7 truncate toward zero", -142);
    energy_div = 8'd1;
    step(1, 5000000, 3'b001);
    expect_done("R7 saturate high", 32767);
    step(1, -5000000, 3'b001);
    expect_done("R7 saturate low", -32768);

    // R8: reset-on-read bit has no effect
    restart(8'h79, 2);
    step(1, 30, 3'b001);
    step(1, 30, 3'b001);
    expect_done("R8 bit6 ignored", 60);

    // R1: disabled mode holds result, no completion
    mode_cfg = 8'h38;
    for (int i = 0; i < 6; i++) begin
      step(1, 999, 3'b111);
      chk(done_pulse == 0, "R1 disabled no done", longint'(done_pulse), 0);
    end
    chk(longint'($signed(energy_out)) == 60, "R1 energy held",
        longint'($signed(energy_out)), 60);
    mode_cfg = 8'h39; cycle_count = 16'd1;
    step(1, 4, 3'b000);
    step(1, 4, 3'b001);
    expect_done("R1 fresh window after enable", 8);

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) mode_cfg = 8'($urandom) | 8'h01;
      if ($urandom_range(0, 199) == 0) mode_cfg[0] = 1'b0;
      if ($urandom_range(0, 29) == 0) cycle_count = 16'($urandom_range(0, 4));
      if ($urandom_range(0, 29) == 0) energy_div = 8'($urandom);
      if ($urandom_range(0, 29) == 0) power_offset = 12'($urandom);
      if ($urandom_range(0, 29) == 0) power_gain = 12'($urandom);
      step(bit'($urandom_range(0, 1)),
           longint'($urandom_range(0, 40000)) - 20000,
           ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule